// File: doc/BRIEF.md
# Serial 4:2:2 Chroma Upsampler

This block sits in front of a video scaler. It turns a stream of YCbCr 4:2:2 samples into 4:4:4 pixels, so that every output pixel carries its own luma and both chroma values. Input samples arrive over a valid/ready handshake, together with a frame-start flag. In serial mode one component arrives per transfer. In parallel mode one word carries the luma of a pixel and one chroma sample. Output pixels leave as a valid-only stream of packed {Y, Cb, Cr} words, with a start flag on the first pixel of each frame.

Pixels at even positions keep the chroma pair sampled with them. Odd pixels take the rounded mean of the chroma of the even pixels on their left and right. At the right edge of a line there is no right-hand neighbour, so the last pixel repeats the chroma of its own pair. The line width comes from an input that holds the width minus one. Every line therefore ends on a pixel count, and the component phase restarts there.

Top module: `cup_upsampler_422`

## Requirements
- R1: With `par_mode`=0, each accepted transfer carries one component in `in_data[DW-1:0]`. The components of a pixel pair come in the order Cb, Y(even), Cr, Y(odd). Bits `in_data[2*DW-1:DW]` are ignored in this mode.
- R2: With `par_mode`=1, `in_data[2*DW-1:DW]` is the luma of one pixel and `in_data[DW-1:0]` is one chroma sample. The first word of a pair carries Cb with the even pixel. The second word carries Cr with the odd pixel.
- R3: `out_pix` is packed as Y in bits [3*DW-1:2*DW], Cb in [2*DW-1:DW] and Cr in [DW-1:0]. An even pixel carries the unmodified Cb and Cr of its own pair.
- R4: An odd pixel that is not the last of its line carries Cb = (Cb_own + Cb_next + 1) >> 1, and Cr computed the same way. Here "next" is the following pair of the same line.
- R5: The line width in pixels is even and equals `line_last_idx`+1. The last pixel of a line repeats the Cb and Cr of its own pair. The next sample after a line's last component starts a new line at pixel 0 with Cb.
- R6: A sample accepted with `in_sof`=1 is taken as the Cb (serial mode) or the first word (parallel mode) of pixel 0. The first output pixel derived from it has `out_sof`=1, and every other output pixel has `out_sof`=0.
- R7: Output pixels appear in input order, at most one per cycle, and none are lost or duplicated. `out_valid` stays high while pixels are stored. `in_ready` falls only when more than four pixels are waiting, so a back-to-back parallel stream is never stalled.
- R8: During and straight after reset, `out_valid`=0, `out_sof`=0 and `in_ready`=1.
- R9: When `in_sof` interrupts a line, the incomplete line yields only the pixels whose right-hand neighbour pair had arrived. The output then continues directly with the new frame's first pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_mode | input | 1 | 0: one component per transfer; 1: luma plus chroma per transfer |
| line_last_idx | input | XW | Line width in pixels minus one (odd) |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_sof | input | 1 | Sample is the first of a frame |
| in_data | input | 2*DW | Input sample |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output pixel is first of a frame |
| out_pix | output | 3*DW | Packed {Y, Cb, Cr} pixel |

## Verification
The assertions assume the following about the inputs:
- `line_last_idx` is odd and held still while a line is in flight.
- `par_mode` changes only while the block is empty.
- A frame starts with `in_sof`.

Under these assumptions the output store can never overflow, and a line-closing pair always drains the held pair. The stimulus keeps within them:
- It switches width and mode only after all expected pixels have been seen.
- It opens every frame with the start flag.
- It breaks a line only by starting a new frame.

// File: rtl/cup_pkg.sv
package cup_pkg;

  // pixel lanes a single pair event can push into the output store
  localparam int unsigned LANES = 4;
  localparam int unsigned PCW   = 3;

  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } comp_ph_e;

  // next component expected after ph; parallel words skip the luma slots
  function automatic comp_ph_e ph_next(input comp_ph_e ph, input logic par);
    comp_ph_e nx;
    unique case (ph)
      PH_CB:   nx = par ? PH_CR : PH_Y0;
      PH_Y0:   nx = PH_CR;
      PH_CR:   nx = par ? PH_CB : PH_Y1;
      default: nx = PH_CB;
    endcase
    return nx;
  endfunction

  function automatic logic ph_closes(input comp_ph_e ph, input logic par);
    return (ph == PH_Y1) || (par && ph == PH_CR);
  endfunction

endpackage

// File: rtl/cup_collect.sv
module cup_collect
  import cup_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned XW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          par_mode,
  input  logic [XW-1:0] line_last_idx,
  input  logic          in_valid,
  input  logic          in_ready,
  input  logic          in_sof,
  input  logic [2*DW-1:0] in_data,
  output logic          pr_vld,
  output logic          pr_sof,
  output logic          pr_first,
  output logic          pr_last,
  output logic [DW-1:0] pr_cb,
  output logic [DW-1:0] pr_y0,
  output logic [DW-1:0] pr_cr,
  output logic [DW-1:0] pr_y1
);

  comp_ph_e      ph_q;
  logic [XW-1:0] xnext_q;
  logic [XW-1:0] base_q;
  logic          sof_q;
  logic [DW-1:0] cb_q, y0_q, cr_q, y1_q;

  logic          take;
  comp_ph_e      ph_eff;
  logic [XW-1:0] base_eff;
  logic          closes;
  logic          is_last;
  logic [DW-1:0] lo_part, hi_part;

  assign take     = in_valid & in_ready;
  assign ph_eff   = in_sof ? PH_CB : ph_q;
  assign base_eff = (ph_eff == PH_CB) ? (in_sof ? '0 : xnext_q) : base_q;
  assign closes   = take & ph_closes(ph_eff, par_mode);
  assign is_last  = (base_eff + XW'(1)) == line_last_idx;
  assign lo_part  = in_data[DW-1:0];
  assign hi_part  = in_data[2*DW-1:DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_CB;
      xnext_q  <= '0;
      base_q   <= '0;
      sof_q    <= 1'b0;
      cb_q     <= '0;
      y0_q     <= '0;
      cr_q     <= '0;
      y1_q     <= '0;
      pr_vld   <= 1'b0;
      pr_sof   <= 1'b0;
      pr_first <= 1'b0;
      pr_last  <= 1'b0;
    end else begin
      pr_vld <= closes;
      if (take) begin
        unique case (ph_eff)
          PH_CB: begin
            cb_q   <= lo_part;
            sof_q  <= in_sof;
            base_q <= base_eff;
            if (par_mode) y0_q <= hi_part;
          end
          PH_Y0: y0_q <= lo_part;
          PH_CR: begin
            cr_q <= lo_part;
            if (par_mode) y1_q <= hi_part;
          end
          default: y1_q <= lo_part;
        endcase
        ph_q <= closes ? PH_CB : ph_next(ph_eff, par_mode);
      end
      if (closes) begin
        xnext_q  <= is_last ? '0 : base_eff + XW'(2);
        pr_first <= (base_eff == '0);
        pr_last  <= is_last;
        pr_sof   <= sof_q;
      end
    end
  end

  assign pr_cb = cb_q;
  assign pr_y0 = y0_q;
  assign pr_cr = cr_q;
  assign pr_y1 = y1_q;

endmodule

// File: rtl/cup_pair_mix.sv
module cup_pair_mix
  import cup_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned EW = 3*DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pr_vld,
  input  logic          pr_sof,
  input  logic          pr_first,
  input  logic          pr_last,
  input  logic [DW-1:0] pr_cb,
  input  logic [DW-1:0] pr_y0,
  input  logic [DW-1:0] pr_cr,
  input  logic [DW-1:0] pr_y1,
  output logic                     pend_vld,
  output logic [PCW-1:0]           push_cnt,
  output logic [LANES-1:0][EW-1:0] push_ent
);

  // rounded mean, half goes up
  function automatic logic [DW-1:0] mean_up(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, 1'b1};
    return s[DW:1];
  endfunction

  logic          pend_sof_q;
  logic [DW-1:0] pend_cb_q, pend_y0_q, pend_cr_q, pend_y1_q;

  logic          emit_held;
  logic          emit_new;
  logic [EW-1:0] held_even, held_odd, new_even, new_odd;

  assign emit_held = pr_vld & pend_vld & ~pr_first;
  assign emit_new  = pr_vld & pr_last;

  assign held_even = {pend_sof_q, pend_y0_q, pend_cb_q, pend_cr_q};
  assign held_odd  = {1'b0, pend_y1_q, mean_up(pend_cb_q, pr_cb), mean_up(pend_cr_q, pr_cr)};
  assign new_even  = {pr_sof, pr_y0, pr_cb, pr_cr};
  assign new_odd   = {1'b0, pr_y1, pr_cb, pr_cr};

  always_comb begin
    push_ent = '0;
    if (emit_held) begin
      push_ent[0] = held_even;
      push_ent[1] = held_odd;
      if (emit_new) begin
        push_ent[2] = new_even;
        push_ent[3] = new_odd;
      end
    end else if (emit_new) begin
      push_ent[0] = new_even;
      push_ent[1] = new_odd;
    end
    push_cnt = {emit_held & emit_new, emit_held ^ emit_new, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld   <= 1'b0;
      pend_sof_q <= 1'b0;
      pend_cb_q  <= '0;
      pend_y0_q  <= '0;
      pend_cr_q  <= '0;
      pend_y1_q  <= '0;
    end else if (pr_vld) begin
      pend_vld   <= ~pr_last;
      pend_sof_q <= pr_sof;
      pend_cb_q  <= pr_cb;
      pend_y0_q  <= pr_y0;
      pend_cr_q  <= pr_cr;
      pend_y1_q  <= pr_y1;
    end
  end

endmodule

// File: rtl/cup_pix_store.sv
module cup_pix_store
  import cup_pkg::*;
#(
  parameter int unsigned EW    = 25,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PCW-1:0]           push_cnt,
  input  logic [LANES-1:0][EW-1:0] push_ent,
  output logic [EW-1:0]            head,
  output logic                     head_vld,
  output logic [CW-1:0]            fill,
  output logic                     room
);

  logic [EW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  assign pop = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (PCW'(k) < push_cnt) mem_q[wr_q + AW'(k)] <= push_ent[k];
      end
      wr_q  <= wr_q + AW'(push_cnt);
      rd_q  <= rd_q + AW'(pop);
      cnt_q <= cnt_q + CW'(push_cnt) - CW'(pop);
    end
  end

  assign head     = mem_q[rd_q];
  assign head_vld = pop;
  assign fill     = cnt_q;
  assign room     = (cnt_q <= CW'(DEPTH - LANES));

endmodule

// File: rtl/cup_upsampler_422.sv
module cup_upsampler_422
  import cup_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned XW         = 12,
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            par_mode,
  input  logic [XW-1:0]   line_last_idx,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_sof,
  input  logic [2*DW-1:0] in_data,
  output logic            out_valid,
  output logic            out_sof,
  output logic [3*DW-1:0] out_pix
);

  localparam int unsigned EW = 3*DW + 1;
  localparam int unsigned CW = $clog2(FIFO_DEPTH) + 1;

  // named internal events, observed by the bound checker
  logic                     pair_vld;
  logic                     pair_sof;
  logic                     pair_first;
  logic                     pair_last;
  logic [DW-1:0]            pair_cb, pair_y0, pair_cr, pair_y1;
  logic                     pend_vld;
  logic [PCW-1:0]           push_cnt;
  logic [LANES-1:0][EW-1:0] push_ent;
  logic [EW-1:0]            head;
  logic                     head_vld;
  logic [CW-1:0]            fifo_cnt;
  logic                     room;

  cup_collect #(.DW(DW), .XW(XW)) u_collect (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .line_last_idx(line_last_idx),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_data(in_data),
    .pr_vld(pair_vld), .pr_sof(pair_sof), .pr_first(pair_first), .pr_last(pair_last),
    .pr_cb(pair_cb), .pr_y0(pair_y0), .pr_cr(pair_cr), .pr_y1(pair_y1)
  );

  cup_pair_mix #(.DW(DW)) u_mix (
    .clk(clk), .rst_n(rst_n), .pr_vld(pair_vld), .pr_sof(pair_sof),
    .pr_first(pair_first), .pr_last(pair_last),
    .pr_cb(pair_cb), .pr_y0(pair_y0), .pr_cr(pair_cr), .pr_y1(pair_y1),
    .pend_vld(pend_vld), .push_cnt(push_cnt), .push_ent(push_ent)
  );

  cup_pix_store #(.EW(EW), .DEPTH(FIFO_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push_cnt(push_cnt), .push_ent(push_ent),
    .head(head), .head_vld(head_vld), .fill(fifo_cnt), .room(room)
  );

  assign in_ready  = room;
  assign out_valid = head_vld;
  assign out_sof   = head_vld & head[EW-1];
  assign out_pix   = head[3*DW-1:0];

endmodule

// File: rtl/cup_upsampler_chk.sv
module cup_upsampler_chk #(
  parameter int unsigned CW    = 4,
  parameter int unsigned PCW   = 3,
  parameter int unsigned DEPTH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           out_valid,
  input logic           out_sof,
  input logic           pair_vld,
  input logic           pair_sof,
  input logic           pair_first,
  input logic           pair_last,
  input logic           pend_vld,
  input logic [PCW-1:0] push_cnt,
  input logic [CW-1:0]  fifo_cnt
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fifo_cnt) + int'(push_cnt)) <= int'(DEPTH)); // R7

  AST_DRAIN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt > CW'(1)) |=> out_valid); // R7

  AST_QUIET_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_vld |-> (push_cnt == '0)); // R7

  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R6

  AST_SOF_IS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_vld && pair_sof) |-> pair_first); // R6

  AST_LINE_END_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_vld && pair_last) |-> (push_cnt != '0)); // R5

  AST_LINE_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_vld && pair_last) |=> !pend_vld); // R5

endmodule

bind cup_upsampler_422 cup_upsampler_chk #(.CW(CW), .PCW(cup_pkg::PCW), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_sof(out_sof),
  .pair_vld(pair_vld), .pair_sof(pair_sof), .pair_first(pair_first), .pair_last(pair_last),
  .pend_vld(pend_vld), .push_cnt(push_cnt), .fifo_cnt(fifo_cnt)
);

// File: tb/cup_upsampler_422_bench.sv
`timescale 1ns/1ps
module cup_upsampler_422_bench;
  localparam int DW = 8;
  localparam int XW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            par_mode = 1'b0;
  logic [XW-1:0]   line_last_idx = XW'(7);
  logic            in_valid = 1'b0;
  logic            in_sof = 1'b0;
  logic [2*DW-1:0] in_data = '0;
  wire             in_ready, out_valid, out_sof;
  wire [3*DW-1:0]  out_pix;

  always #2.5 clk = ~clk;

  cup_upsampler_422 u_cup_upsampler_422 (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .line_last_idx(line_last_idx),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_data(in_data),
    .out_valid(out_valid), .out_sof(out_sof), .out_pix(out_pix)
  );

  typedef struct packed {logic sof; logic [DW-1:0] y; logic [DW-1:0] cb; logic [DW-1:0] cr;} px_t;

  int    checks = 0;
  int    errors = 0;
  int    stalls = 0;
  int    cyc = 0;
  px_t   exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: compare each produced pixel against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      px_t got;
      got = {out_sof, out_pix};
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected pixel", 32'(got), 32'h0);
      end else begin
        px_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got === e, t, 32'(got), 32'(e));
      end
    end
    if (in_valid && !in_ready) stalls++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "R7 watchdog expired", 32'(cyc), 32'd150000);
      report();
    end
  end

  function automatic logic [DW-1:0] mean_up(input logic [DW-1:0] a, input logic [DW-1:0] b);
    int s;
    s = (int'(a) + int'(b) + 1) / 2;
    return DW'(s);
  endfunction

  function automatic logic [DW-1:0] pick(input bit extreme);
    logic [DW-1:0] v;
    if (extreme) begin
      case ($urandom % 4)
        0: v = 8'd0;
        1: v = 8'd1;
        2: v = 8'd254;
        default: v = 8'd255;
      endcase
    end else v = DW'($urandom);
    return v;
  endfunction

  task automatic put(input logic [DW-1:0] hi, input logic [DW-1:0] lo, input logic sof, input int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = {hi, lo};
    in_sof   = sof;
    while (!in_ready) @(negedge clk);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  // one line: width pixels, only npairs pairs actually sent
  task automatic send_line(input int width, input int npairs, input bit par, input bit sof,
                           input int gap, input bit garb, input bit extreme, input bit after_cut);
    logic [DW-1:0] ly[64];
    logic [DW-1:0] lcb[32];
    logic [DW-1:0] lcr[32];
    string mt;
    mt = par ? "R2" : "R1";
    for (int p = 0; p < npairs; p++) begin
      lcb[p] = pick(extreme);
      lcr[p] = pick(extreme);
      ly[2*p] = pick(0);
      ly[2*p+1] = pick(0);
    end
    for (int p = 0; p < npairs; p++) begin
      bit lastp;
      lastp = (p == width/2 - 1);
      if (lastp || (p + 1 < npairs)) begin
        exp_q.push_back({sof && p == 0, ly[2*p], lcb[p], lcr[p]});
        if (after_cut && p == 0) tag_q.push_back($sformatf("%s R9 first pixel after cut", mt));
        else if (sof && p == 0) tag_q.push_back($sformatf("%s R6 frame start pixel", mt));
        else tag_q.push_back($sformatf("%s R3 even pixel %0d", mt, 2*p));
        if (lastp) begin
          exp_q.push_back({1'b0, ly[2*p+1], lcb[p], lcr[p]});
          tag_q.push_back($sformatf("%s R5 line end pixel %0d", mt, 2*p+1));
        end else begin
          exp_q.push_back({1'b0, ly[2*p+1], mean_up(lcb[p], lcb[p+1]), mean_up(lcr[p], lcr[p+1])});
          tag_q.push_back($sformatf("%s R4 odd pixel %0d", mt, 2*p+1));
        end
      end
    end
    for (int p = 0; p < npairs; p++) begin
      if (par) begin
        put(ly[2*p], lcb[p], sof && p == 0, gap);
        put(ly[2*p+1], lcr[p], 1'b0, gap);
      end else begin
        put(garb ? pick(0) : '0, lcb[p], sof && p == 0, gap);
        put(garb ? pick(0) : '0, ly[2*p], 1'b0, gap);
        put(garb ? pick(0) : '0, lcr[p], 1'b0, gap);
        put(garb ? pick(0) : '0, ly[2*p+1], 1'b0, gap);
      end
    end
  endtask

  task automatic drain();
    int n;
    idle();
    n = 0;
    while ((exp_q.size() != 0 || out_valid) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 all expected pixels produced", 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid in reset", 32'(out_valid), 32'd0);
    check(out_sof == 1'b0, "R8 out_sof in reset", 32'(out_sof), 32'd0);
    check(in_ready == 1'b1, "R8 in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R8 in_ready after reset", 32'(in_ready), 32'd1);

    // serial, high bits carry noise, two lines of width 8
    par_mode = 1'b0; line_last_idx = XW'(7);
    send_line(8, 4, 1'b0, 1'b1, 0, 1'b1, 1'b0, 1'b0);
    send_line(8, 4, 1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b0);
    drain();

    // serial, narrowest line: one pair, chroma repeated
    line_last_idx = XW'(1);
    send_line(2, 1, 1'b0, 1'b1, 1, 1'b1, 1'b0, 1'b0);
    send_line(2, 1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    drain();

    // parallel, back-to-back, width 16, no stall expected
    par_mode = 1'b1; line_last_idx = XW'(15);
    stalls = 0;
    send_line(16, 8, 1'b1, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    send_line(16, 8, 1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    send_line(16, 8, 1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    drain();
    check(stalls == 0, "R7 no stall on back-to-back parallel stream", 32'(stalls), 32'd0);

    // parallel with idle gaps and extreme chroma for rounding
    line_last_idx = XW'(11);
    send_line(12, 6, 1'b1, 1'b1, 1, 1'b0, 1'b1, 1'b0);
    send_line(12, 6, 1'b1, 1'b0, 2, 1'b0, 1'b1, 1'b0);
    drain();

    // serial, extreme chroma rounding
    par_mode = 1'b0; line_last_idx = XW'(9);
    send_line(10, 5, 1'b0, 1'b1, 0, 1'b0, 1'b1, 1'b0);
    drain();

    // serial line cut short by a new frame
    line_last_idx = XW'(7);
    send_line(8, 3, 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    send_line(8, 4, 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b1);
    drain();

    // parallel line cut short by a new frame
    par_mode = 1'b1; line_last_idx = XW'(15);
    send_line(16, 5, 1'b1, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    send_line(16, 8, 1'b1, 1'b1, 1, 1'b0, 1'b0, 1'b1);
    drain();

    report();
  end

endmodule